// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a byte queue of instruction bytes full ahead of the decoder. It holds one fetch pointer, the address of the next byte to fetch. It issues aligned bus-word reads from that pointer and appends the bytes that come back to the queue. The bus word is 1, 2 or 4 bytes wide. The instruction pointer seen by the core is never stored. It is always formed as the fetch pointer minus the number of bytes still waiting in the queue.

A jump loads the fetch pointer from a target address and empties the queue. When the jump uses a 16-bit operand size, the upper half of the target is cleared. An external stall, standing for a translation miss, holds back new reads. A segment limit input stops prefetching quietly at the last legal byte. The fault itself is left to the execution side. Memory latency belongs to the memory side. The block keeps at most one read in flight.

Top module: `pfq_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, the queue count is 0, `dq_valid_o` is low, no read is issued, and `ip_o` equals the reset address (default 0).
- R2: `ip_o` always equals the fetch pointer minus the queue count. Each accepted dequeue raises it by one, and enqueued bytes leave it unchanged.
- R3: A read address is aligned to the bus width. Byte lane j of `mem_rdata_i[8j+7:8j]` holds address `mem_addr_o + j`. `mem_be_o` marks a contiguous run of lanes starting at the fetch pointer's lane offset. The run is clipped to the end of the word, to the free queue space and to the limit.
- R4: Bytes leave the queue in address order, and each carries the memory byte of its own address.
- R5: At most one read is outstanding, and no read is issued while the queue holds DEPTH bytes.
- R6: An enqueue and a dequeue in the same cycle change the count by their net effect. A dequeue request on an empty queue is ignored.
- R7: A jump empties the queue, and from the next cycle `ip_o` equals the loaded target.
- R8: With `jump_narrow_i` high, bits 31..16 of the loaded pointer are zero and bits 15..0 come from the target.
- R9: Data returning for a read issued before a jump is discarded. The first byte after the jump comes from the target address.
- R10: While `xlat_stall_i` is high, no new read is issued, and bytes already queued can still be dequeued.
- R11: No read is issued once the fetch pointer passes `seg_limit_i`. No byte past the limit is enqueued, and no fault is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jump_i | input | 1 | Load fetch pointer from target and empty queue |
| jump_target_i | input | 32 | Jump target address |
| jump_narrow_i | input | 1 | 16-bit operand size jump: clear upper pointer half |
| xlat_stall_i | input | 1 | Translation miss: hold back new reads |
| seg_limit_i | input | 32 | Last fetchable offset |
| mem_req_o | output | 1 | One-cycle read request pulse |
| mem_addr_o | output | 32 | Bus-aligned read address |
| mem_be_o | output | BUS_BYTES | Lanes to be kept from the response |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8*BUS_BYTES | Read data, lane j = address + j |
| dq_take_i | input | 1 | Decoder takes the head byte |
| dq_valid_o | output | 1 | Queue not empty |
| dq_byte_o | output | 8 | Head byte |
| dq_count_o | output | $clog2(DEPTH+1) | Bytes in queue |
| ip_o | output | 32 | Architectural instruction pointer |

## Verification
A wrong occupancy count appears at once on `ip_o`, since the pointer is derived from it. Within the next few dequeues it also shows as a byte that does not match its address, or as reads still issued while the queue is full. A lost drop flag after a jump lets stale bytes in, so the first dequeued byte after the jump no longer matches the target address. A bad lane offset or clip shows on `mem_be_o` in the very cycle the read is issued. A stream of dequeues with each byte compared against its own address catches slips in the queue pointers within one queue depth.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int PFQ_AW = 32;

  typedef struct packed {
    logic [PFQ_AW-1:0] target;
    logic              narrow;
  } pfq_jump_t;

  // Pointer value a jump loads: 16-bit operand size zeroes the upper half.
  function automatic logic [PFQ_AW-1:0] pfq_jump_addr(pfq_jump_t j);
    return j.narrow ? {16'h0000, j.target[15:0]} : j.target;
  endfunction
endpackage

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl #(
  parameter int          BUS_BYTES  = 4,
  parameter int          DEPTH      = 16,
  parameter logic [31:0] RESET_ADDR = 32'h0,
  parameter int          CNT_W      = $clog2(DEPTH + 1),
  parameter int          OFF_W      = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1,
  parameter int          N_W        = $clog2(BUS_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic [31:0]          flush_addr,
  input  logic                 stall,
  input  logic [31:0]          limit,
  input  logic [CNT_W-1:0]     free,
  input  logic                 rvalid,
  output logic                 req,
  output logic [31:0]          req_addr,
  output logic [BUS_BYTES-1:0] req_be,
  output logic                 enq_valid,
  output logic [OFF_W-1:0]     enq_off,
  output logic [N_W-1:0]       enq_n,
  output logic [31:0]          fptr
);
  localparam logic [31:0] LANE_MASK = 32'(BUS_BYTES - 1);

  logic [31:0]          fptr_q;
  logic                 pend_q, drop_q, req_q;
  logic [31:0]          addr_q;
  logic [BUS_BYTES-1:0] be_q;
  logic [OFF_W-1:0]     poff_q;
  logic [N_W-1:0]       pn_q;

  logic [OFF_W-1:0]     off;
  logic [31:0]          aligned;
  logic                 in_limit;
  logic [32:0]          span_lim, lane_room, n_a, n33;
  logic [N_W-1:0]       n;
  logic [BUS_BYTES-1:0] be;
  logic                 can_issue, resp;

  always_comb begin
    off       = OFF_W'(fptr_q & LANE_MASK);
    aligned   = fptr_q & ~LANE_MASK;
    in_limit  = fptr_q <= limit;
    span_lim  = {1'b0, limit} - {1'b0, fptr_q} + 33'd1;
    lane_room = 33'(BUS_BYTES) - 33'(off);
    n_a       = (lane_room < 33'(free)) ? lane_room : 33'(free);
    n33       = (n_a < span_lim) ? n_a : span_lim;
    n         = N_W'(n33);
  end

  generate
    for (genvar j = 0; j < BUS_BYTES; j++) begin : g_be
      assign be[j] = (j >= int'(off)) && (j < int'(off) + int'(n));
    end
  endgenerate

  assign can_issue = !pend_q && !flush && !stall && in_limit && (free != '0);
  assign resp      = pend_q && rvalid;
  assign enq_valid = resp && !drop_q && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      fptr_q <= RESET_ADDR;
      pend_q <= 1'b0;
      drop_q <= 1'b0;
      req_q  <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
      poff_q <= '0;
      pn_q   <= '0;
    end else begin
      req_q <= 1'b0;
      if (resp) begin
        pend_q <= 1'b0;
        drop_q <= 1'b0;
        if (enq_valid) fptr_q <= fptr_q + 32'(pn_q);
      end
      if (flush) begin
        fptr_q <= flush_addr;
        if (pend_q && !rvalid) drop_q <= 1'b1;
      end else if (can_issue) begin
        req_q  <= 1'b1;
        pend_q <= 1'b1;
        addr_q <= aligned;
        be_q   <= be;
        poff_q <= off;
        pn_q   <= n;
      end
    end
  end

  assign req      = req_q;
  assign req_addr = addr_q;
  assign req_be   = be_q;
  assign enq_off  = poff_q;
  assign enq_n    = pn_q;
  assign fptr     = fptr_q;
endmodule

// File: rtl/pfq_byte_queue.sv
module pfq_byte_queue #(
  parameter int BUS_BYTES = 4,
  parameter int DEPTH     = 16,
  parameter int CNT_W     = $clog2(DEPTH + 1),
  parameter int OFF_W     = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1,
  parameter int N_W       = $clog2(BUS_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   enq_valid,
  input  logic [OFF_W-1:0]       enq_off,
  input  logic [N_W-1:0]         enq_n,
  input  logic [8*BUS_BYTES-1:0] enq_data,
  input  logic                   deq_req,
  output logic [7:0]             head,
  output logic [CNT_W-1:0]       count,
  output logic                   valid
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       wbyte [BUS_BYTES];
  logic             do_deq;

  // Slot k of a write takes the lane at (offset + k).
  generate
    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      assign wbyte[k] = 8'(enq_data >> (8 * (int'(enq_off) + k)));
    end
  endgenerate

  assign do_deq = deq_req && (cnt_q != '0) && !flush;

  always_ff @(posedge clk) begin
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (enq_valid && (k < int'(enq_n))) store[wr_q + PTR_W'(k)] <= wbyte[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (enq_valid) wr_q <= wr_q + PTR_W'(enq_n);
      if (do_deq)    rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (enq_valid ? CNT_W'(enq_n) : '0) - CNT_W'(do_deq);
    end
  end

  assign head  = store[rd_q];
  assign count = cnt_q;
  assign valid = cnt_q != '0;
endmodule

// File: rtl/pfq_unit.sv
module pfq_unit #(
  parameter int          BUS_BYTES  = 4,
  parameter int          DEPTH      = 16,
  parameter logic [31:0] RESET_ADDR = 32'h0,
  localparam int         CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   jump_i,
  input  logic [31:0]            jump_target_i,
  input  logic                   jump_narrow_i,
  input  logic                   xlat_stall_i,
  input  logic [31:0]            seg_limit_i,
  output logic                   mem_req_o,
  output logic [31:0]            mem_addr_o,
  output logic [BUS_BYTES-1:0]   mem_be_o,
  input  logic                   mem_rvalid_i,
  input  logic [8*BUS_BYTES-1:0] mem_rdata_i,
  input  logic                   dq_take_i,
  output logic                   dq_valid_o,
  output logic [7:0]             dq_byte_o,
  output logic [CNT_W-1:0]       dq_count_o,
  output logic [31:0]            ip_o
);
  import pfq_pkg::*;

  localparam int OFF_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;
  localparam int N_W   = $clog2(BUS_BYTES + 1);

  pfq_jump_t        jmp;
  logic [31:0]      load_addr;
  logic [CNT_W-1:0] count, free;
  logic [31:0]      fptr;
  logic             enq_valid;
  logic [OFF_W-1:0] enq_off;
  logic [N_W-1:0]   enq_n;

  assign jmp       = '{target: jump_target_i, narrow: jump_narrow_i};
  assign load_addr = pfq_jump_addr(jmp);
  assign free      = CNT_W'(DEPTH) - count;

  pfq_fetch_ctl #(
    .BUS_BYTES(BUS_BYTES), .DEPTH(DEPTH), .RESET_ADDR(RESET_ADDR),
    .CNT_W(CNT_W), .OFF_W(OFF_W), .N_W(N_W)
  ) u_fetch (
    .clk(clk), .rst(rst), .flush(jump_i), .flush_addr(load_addr),
    .stall(xlat_stall_i), .limit(seg_limit_i), .free(free),
    .rvalid(mem_rvalid_i), .req(mem_req_o), .req_addr(mem_addr_o),
    .req_be(mem_be_o), .enq_valid(enq_valid), .enq_off(enq_off),
    .enq_n(enq_n), .fptr(fptr)
  );

  pfq_byte_queue #(
    .BUS_BYTES(BUS_BYTES), .DEPTH(DEPTH), .CNT_W(CNT_W),
    .OFF_W(OFF_W), .N_W(N_W)
  ) u_queue (
    .clk(clk), .rst(rst), .flush(jump_i), .enq_valid(enq_valid),
    .enq_off(enq_off), .enq_n(enq_n), .enq_data(mem_rdata_i),
    .deq_req(dq_take_i), .head(dq_byte_o), .count(count),
    .valid(dq_valid_o)
  );

  assign dq_count_o = count;
  assign ip_o       = fptr - 32'(count);
endmodule

// File: rtl/pfq_unit_chk.sv
module pfq_unit_chk #(
  parameter int BUS_BYTES = 4,
  parameter int DEPTH     = 16,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 jump_i,
  input logic [31:0]          jump_target_i,
  input logic                 jump_narrow_i,
  input logic                 xlat_stall_i,
  input logic [31:0]          seg_limit_i,
  input logic                 mem_req_o,
  input logic [31:0]          mem_addr_o,
  input logic [BUS_BYTES-1:0] mem_be_o,
  input logic                 mem_rvalid_i,
  input logic                 dq_take_i,
  input logic                 dq_valid_o,
  input logic [CNT_W-1:0]     dq_count_o,
  input logic [31:0]          ip_o
);
  logic [1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else out_q <= out_q + 2'(mem_req_o) - 2'(mem_rvalid_i && (out_q != '0));
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (dq_count_o == '0 && !dq_valid_o && !mem_req_o));

  p_ip_step_r2: assert property (@(posedge clk) disable iff (rst)
    (dq_take_i && dq_valid_o && !jump_i) |=> ip_o == $past(ip_o) + 32'd1);

  p_ip_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!dq_take_i && !jump_i) |=> $stable(ip_o));

  p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> ((mem_addr_o & 32'(BUS_BYTES - 1)) == '0 && mem_be_o != '0));

  p_one_out_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> out_q == '0);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    dq_count_o <= CNT_W'(DEPTH));

  p_net_count_r6: assert property (@(posedge clk) disable iff (rst)
    (dq_take_i && dq_valid_o && !jump_i && !mem_rvalid_i)
      |=> dq_count_o == $past(dq_count_o) - 1'b1);

  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (jump_i && !jump_narrow_i) |=> (dq_count_o == '0 && ip_o == $past(jump_target_i)));

  p_narrow_r8: assert property (@(posedge clk) disable iff (rst)
    (jump_i && jump_narrow_i)
      |=> ip_o == {16'h0000, $past(jump_target_i[15:0])});

  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    xlat_stall_i |=> !mem_req_o);

  p_limit_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && $stable(seg_limit_i)) |-> mem_addr_o <= seg_limit_i);
endmodule

bind pfq_unit pfq_unit_chk #(.BUS_BYTES(BUS_BYTES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .jump_i(jump_i), .jump_target_i(jump_target_i),
  .jump_narrow_i(jump_narrow_i), .xlat_stall_i(xlat_stall_i),
  .seg_limit_i(seg_limit_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_be_o(mem_be_o), .mem_rvalid_i(mem_rvalid_i), .dq_take_i(dq_take_i),
  .dq_valid_o(dq_valid_o), .dq_count_o(dq_count_o), .ip_o(ip_o)
);

// File: tb/tb_pfq_unit.sv
`timescale 1ns/1ps
module tb_pfq_unit;
  localparam int BB    = 4;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          jump_i = 1'b0;
  logic [31:0]   jump_target_i = '0;
  logic          jump_narrow_i = 1'b0;
  logic          xlat_stall_i = 1'b1;
  logic [31:0]   seg_limit_i = 32'hFFFF_FFFF;
  logic          mem_req_o;
  logic [31:0]   mem_addr_o;
  logic [BB-1:0] mem_be_o;
  logic          mem_rvalid_i;
  logic [8*BB-1:0] mem_rdata_i;
  logic          dq_take_i = 1'b0;
  logic          dq_valid_o;
  logic [7:0]    dq_byte_o;
  logic [CW-1:0] dq_count_o;
  logic [31:0]   ip_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  pfq_unit #(.BUS_BYTES(BB), .DEPTH(DEPTH)) dut (.*);

  function automatic logic [7:0] fb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // Memory model: two-cycle read latency.
  logic        p0 = 1'b0, p1 = 1'b0;
  logic [31:0] a0 = '0, a1 = '0;
  always @(posedge clk) begin
    p0 <= mem_req_o; a0 <= mem_addr_o;
    p1 <= p0;        a1 <= a0;
  end
  assign mem_rvalid_i = p1;
  always_comb
    for (int j = 0; j < BB; j++) mem_rdata_i[8*j +: 8] = fb(a1 + 32'(j));

  // Request log.
  int unsigned log_total = 0;
  logic [31:0]   log_addr [64];
  logic [BB-1:0] log_be   [64];
  always @(posedge clk) begin
    if (!rst && mem_req_o) begin
      log_addr[log_total[5:0]] <= mem_addr_o;
      log_be[log_total[5:0]]   <= mem_be_o;
      log_total <= log_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Called at a negedge; the jump takes effect at the next edge.
  task automatic do_jump(input logic [31:0] t, input logic nar);
    jump_i = 1'b1; jump_target_i = t; jump_narrow_i = nar;
    @(negedge clk);
    jump_i = 1'b0; jump_narrow_i = 1'b0;
  endtask

  task automatic wait_count(input int n);
    for (int i = 0; i < 300 && int'(dq_count_o) != n; i++) @(negedge clk);
  endtask

  task automatic pop_check(input logic [31:0] exp_addr, input string req);
    chk(dq_valid_o && dq_byte_o == fb(exp_addr), req, {24'h0, dq_byte_o}, {24'h0, fb(exp_addr)});
    chk(ip_o == exp_addr, "R2 ip before pop", ip_o, exp_addr);
    dq_take_i = 1'b1;
    @(negedge clk);
    dq_take_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(dq_count_o == '0, "R1 count", 32'(dq_count_o), 0);
    chk(!dq_valid_o && !mem_req_o, "R1 idle", {30'h0, dq_valid_o, mem_req_o}, 0);
    chk(ip_o == 32'h0, "R1 ip", ip_o, 0);
  endtask

  task automatic t_narrow();
    xlat_stall_i = 1'b1;
    do_jump(32'hABCD_1234, 1'b1);
    chk(ip_o == 32'h0000_1234, "R8 narrow jump", ip_o, 32'h1234);
    do_jump(32'hABCD_1234, 1'b0);
    chk(ip_o == 32'hABCD_1234, "R7 wide jump", ip_o, 32'hABCD_1234);
    chk(dq_count_o == '0, "R7 queue empty", 32'(dq_count_o), 0);
  endtask

  task automatic t_empty_deq();
    xlat_stall_i = 1'b1;
    do_jump(32'h6000, 1'b0);
    dq_take_i = 1'b1; cycles(3); dq_take_i = 1'b0;
    chk(dq_count_o == '0 && ip_o == 32'h6000, "R6 empty dequeue ignored", ip_o, 32'h6000);
    xlat_stall_i = 1'b0;
    wait_count(4);
    pop_check(32'h6000, "R6 first byte after ignored pops");
    xlat_stall_i = 1'b1;
  endtask

  task automatic t_misalign();
    int unsigned b;
    xlat_stall_i = 1'b1;
    do_jump(32'h2003, 1'b0);
    b = log_total;
    xlat_stall_i = 1'b0;
    wait_count(5);
    xlat_stall_i = 1'b1;
    chk(log_addr[b[5:0]] == 32'h2000 && log_be[b[5:0]] == 4'b1000, "R3 misaligned start",
        {log_addr[b[5:0]][27:0], log_be[b[5:0]]}, 32'h2000_0008);
    chk(log_addr[(b + 1) & 63] == 32'h2004 && log_be[(b + 1) & 63] == 4'b1111,
        "R3 next word full", log_addr[(b + 1) & 63], 32'h2004);
    pop_check(32'h2003, "R4 byte 0x2003");
    pop_check(32'h2004, "R4 byte 0x2004");
  endtask

  task automatic t_full();
    int unsigned b;
    xlat_stall_i = 1'b1;
    do_jump(32'h1000, 1'b0);
    xlat_stall_i = 1'b0;
    wait_count(DEPTH);
    chk(int'(dq_count_o) == DEPTH, "R5 queue fills", 32'(dq_count_o), DEPTH);
    b = log_total;
    cycles(20);
    chk(log_total == b, "R5 no read while full", log_total - b, 0);
    b = log_total;
    pop_check(32'h1000, "R4 head when full");
    wait_count(DEPTH);
    chk(log_total - b == 1 && log_addr[b[5:0]] == 32'h1010 && log_be[b[5:0]] == 4'b0001,
        "R3 clip to free space", {log_addr[b[5:0]][27:0], log_be[b[5:0]]}, 32'h1010_0001);
    chk(ip_o == 32'h1001, "R2 ip after refill", ip_o, 32'h1001);
  endtask

  task automatic t_stall();
    int unsigned b;
    xlat_stall_i = 1'b1;
    pop_check(32'h1001, "R10 pop under stall");
    pop_check(32'h1002, "R10 pop under stall");
    pop_check(32'h1003, "R10 pop under stall");
    b = log_total;
    cycles(20);
    chk(log_total == b, "R10 no read while stalled", log_total - b, 0);
    chk(int'(dq_count_o) == DEPTH - 3, "R10 count kept", 32'(dq_count_o), DEPTH - 3);
    xlat_stall_i = 1'b0;
    wait_count(DEPTH);
    chk(int'(dq_count_o) == DEPTH, "R10 refill after release", 32'(dq_count_o), DEPTH);
    xlat_stall_i = 1'b1;
  endtask

  task automatic t_flush_pending();
    int unsigned b;
    xlat_stall_i = 1'b1;
    do_jump(32'h4000, 1'b0);
    b = log_total;
    xlat_stall_i = 1'b0;
    for (int i = 0; i < 50 && log_total == b; i++) @(negedge clk);
    do_jump(32'h5000, 1'b0);
    wait_count(4);
    xlat_stall_i = 1'b1;
    chk(log_addr[(b + 1) & 63] == 32'h5000, "R9 refetch from target", log_addr[(b + 1) & 63], 32'h5000);
    pop_check(32'h5000, "R9 stale data dropped");
  endtask

  task automatic t_limit();
    int unsigned b;
    xlat_stall_i = 1'b1;
    seg_limit_i = 32'h3005;
    do_jump(32'h3002, 1'b0);
    b = log_total;
    xlat_stall_i = 1'b0;
    cycles(30);
    chk(log_total - b == 2, "R11 two reads then stop", log_total - b, 2);
    chk(log_addr[b[5:0]] == 32'h3000 && log_be[b[5:0]] == 4'b1100, "R11 first word",
        {log_addr[b[5:0]][27:0], log_be[b[5:0]]}, 32'h3000_000C);
    chk(log_addr[(b + 1) & 63] == 32'h3004 && log_be[(b + 1) & 63] == 4'b0011, "R11 clipped word",
        {log_addr[(b + 1) & 63][27:0], log_be[(b + 1) & 63]}, 32'h3004_0003);
    chk(int'(dq_count_o) == 4, "R11 four bytes", 32'(dq_count_o), 4);
    for (int i = 0; i < 4; i++) pop_check(32'h3002 + 32'(i), "R11 bytes up to limit");
    b = log_total;
    cycles(10);
    chk(!dq_valid_o && log_total == b, "R11 quiet stop at limit", log_total - b, 0);
    xlat_stall_i = 1'b1;
    seg_limit_i = 32'hFFFF_FFFF;
  endtask

  task automatic t_stream();
    logic [31:0] exp_a;
    xlat_stall_i = 1'b1;
    do_jump(32'h8000, 1'b0);
    exp_a = 32'h8000;
    xlat_stall_i = 1'b0;
    dq_take_i = 1'b1;
    for (int i = 0; i < 80; i++) begin
      if (dq_valid_o) begin
        chk(dq_byte_o == fb(exp_a) && ip_o == exp_a, "R6 stream enq+deq",
            {ip_o[23:0], dq_byte_o}, {exp_a[23:0], fb(exp_a)});
        exp_a++;
      end
      @(negedge clk);
    end
    dq_take_i = 1'b0;
    chk(exp_a - 32'h8000 >= 32'd20, "R6 stream progress", exp_a - 32'h8000, 20);
    xlat_stall_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    cycles(4);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_empty_deq();
    t_misalign();
    t_full();
    t_stall();
    t_flush_pending();
    t_limit();
    t_stream();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule